// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block is a small, fully associative cache of address translations. Each entry maps a virtual page number to a physical page number. Each entry also carries a global flag and the address-space identifier of the task that owns it. A lookup presents a virtual address together with the identifier of the running task. One cycle later the block returns a hit with its physical page, a miss, or a translation fault for a malformed address.

When the lookup misses, the result also says which of the two page-table roots a walker should use. The lower root serves the bottom of the address space and the upper root serves the top. Fill and invalidate commands keep the contents current. Entries that belong to different tasks can sit side by side, even for the same page, so a context switch only changes the identifier on the lookup port and never flushes the table.

The address is `VA_W` bits wide, with `PAGE_W` offset bits. A valid address has the bits from `IA_W-1` up to the top all equal: all zeros for the lower region, all ones for the upper region.

Top module: `asid_tlb`

## Requirements
- R1: After reset no entry is valid, `rsp_valid` is 0, and every lookup in any address space misses.
- R2: A non-global entry hits only when its page number equals `lk_va[VA_W-1:PAGE_W]` and its stored identifier equals `lk_asid`. On a hit `rsp_ppn` carries that entry's physical page. On a miss or a fault `rsp_ppn` is 0.
- R3: A global entry (`fill_global`=1) hits on a page match for every value of `lk_asid`.
- R4: Two or more valid entries for the same page with different identifiers coexist. A lookup with each identifier returns that identifier's physical page, with no invalidation in between.
- R5: A canonical lookup that matches no entry sets `rsp_miss`=1 and `rsp_hit`=0. For every lookup, `rsp_upper` equals `lk_va[VA_W-1]` (1 selects the upper root). Exactly one of hit, miss and fault is set on each response.
- R6: An address whose bits `[VA_W-1:IA_W-1]` are neither all zeros nor all ones gives `rsp_fault`=1, `rsp_hit`=0 and `rsp_miss`=0, even when its page number is present in the table.
- R7: A fill that matches no existing entry writes the lowest-indexed invalid entry. If every entry is valid, it writes the entry under a replacement pointer instead. The pointer starts at 0 after reset and advances by one, wrapping modulo `ENTRIES`, only on such replacements.
- R8: A fill whose page number and global flag equal those of a valid entry (and, for non-global, whose identifier also matches) overwrites that entry in place. No other entry is displaced.
- R9: `inv_asid_en` clears every non-global entry whose identifier equals `inv_asid`. Global entries and other identifiers' entries stay valid.
- R10: `inv_all` clears every entry. A fill in the same cycle is applied after the invalidation, so the filled entry remains valid.
- R11: `rsp_valid` and the result fields are registered one cycle after `lk_valid`. A lookup in the same cycle as a fill or an invalidate sees the table as it was before that cycle.
- R12: When several entries match one lookup (for example a global and a non-global entry for the same page), the lowest-indexed one supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Virtual address to translate |
| lk_asid | input | ASID_W | Identifier of the running task |
| fill_en | input | 1 | Write a translation |
| fill_vpn | input | VA_W-PAGE_W | Virtual page number to write |
| fill_ppn | input | PPN_W | Physical page number to write |
| fill_global | input | 1 | 1 = entry applies to all tasks |
| fill_asid | input | ASID_W | Owner identifier for a non-global fill |
| inv_asid_en | input | 1 | Invalidate non-global entries of one identifier |
| inv_asid | input | ASID_W | Identifier to invalidate |
| inv_all | input | 1 | Invalidate every entry |
| rsp_valid | output | 1 | Result valid, one cycle after `lk_valid` |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | No translation; a walk is needed |
| rsp_fault | output | 1 | Non-canonical address |
| rsp_upper | output | 1 | 1 = upper root, 0 = lower root |
| rsp_ppn | output | PPN_W | Physical page number on a hit, else 0 |

## Verification
A lookup can land in the same cycle as a fill or as an invalidate. The contract in that case is that the lookup reports the contents from before the edge. The bench provokes this by driving a lookup together with a fill that replaces the very entry being looked up, and together with `inv_all` and `inv_asid_en`. It judges the registered result against the table as it stood before the update. A lookup in the following cycle must then show the new contents. A fill sharing its cycle with `inv_all` is judged by the filled entry alone surviving.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
  // where a fill lands
  typedef enum logic [1:0] {
    SLOT_REUSE = 2'd0,
    SLOT_FREE  = 2'd1,
    SLOT_RR    = 2'd2
  } slot_src_e;
endpackage

// File: rtl/tlb_cam_match.sv
module tlb_cam_match #(
  parameter int N       = 16,
  parameter int VPN_W   = 36,
  parameter int ASID_W  = 8,
  parameter int IDX_W   = 4,
  parameter bit FILL_KEY = 1'b0
) (
  input  logic [N-1:0]      valid,
  input  logic [VPN_W-1:0]  vpn  [N],
  input  logic [N-1:0]      glob,
  input  logic [ASID_W-1:0] asid [N],
  input  logic [VPN_W-1:0]  key_vpn,
  input  logic [ASID_W-1:0] key_asid,
  input  logic              key_glob,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  logic [N-1:0] m;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    if (FILL_KEY) begin : g_fill
      // same page, same scope, same owner when non-global
      assign m[i] = valid[i] && (vpn[i] == key_vpn) && (glob[i] == key_glob) &&
                    (key_glob || (asid[i] == key_asid));
    end else begin : g_look
      assign m[i] = valid[i] && (vpn[i] == key_vpn) &&
                    (glob[i] || (asid[i] == key_asid));
    end
  end

  always_comb begin
    hit = |m;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (m[i]) idx = IDX_W'(i);  // lowest index wins (R12)
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
  import asid_tlb_pkg::*;
#(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fill_en,
  input  logic [N-1:0]     valid,
  input  logic             reuse_hit,
  input  logic [IDX_W-1:0] reuse_idx,
  output logic [IDX_W-1:0] slot
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             free_hit;
  slot_src_e        src;

  always_comb begin
    free_hit = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        free_hit = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
    if (reuse_hit)     src = SLOT_REUSE;
    else if (free_hit) src = SLOT_FREE;
    else               src = SLOT_RR;
    case (src)
      SLOT_REUSE: slot = reuse_idx;
      SLOT_FREE:  slot = free_idx;
      default:    slot = rr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rr_q <= '0;
    else if (fill_en && src == SLOT_RR)
      rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
  end

  p_free_slot_r7: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !reuse_hit && !(&valid)) |-> !valid[slot]);
  p_rr_step_r7: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !reuse_hit && (&valid)) |=>
      (int'(rr_q) == ((int'($past(rr_q)) + 1) % N)));
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 48,
  parameter int PAGE_W  = 12,
  parameter int IA_W    = 39,
  parameter int ASID_W  = 8,
  parameter int PPN_W   = 28
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     lk_valid,
  input  logic [VA_W-1:0]          lk_va,
  input  logic [ASID_W-1:0]        lk_asid,
  input  logic                     fill_en,
  input  logic [VA_W-PAGE_W-1:0]   fill_vpn,
  input  logic [PPN_W-1:0]         fill_ppn,
  input  logic                     fill_global,
  input  logic [ASID_W-1:0]        fill_asid,
  input  logic                     inv_asid_en,
  input  logic [ASID_W-1:0]        inv_asid,
  input  logic                     inv_all,
  output logic                     rsp_valid,
  output logic                     rsp_hit,
  output logic                     rsp_miss,
  output logic                     rsp_fault,
  output logic                     rsp_upper,
  output logic [PPN_W-1:0]         rsp_ppn
);
  localparam int VPN_W = VA_W - PAGE_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int TOP_W = VA_W - IA_W + 1;

  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] glob_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];

  logic             lk_hit, fm_hit;
  logic [IDX_W-1:0] lk_idx, fm_idx, slot;
  logic [TOP_W-1:0] lk_top;
  logic             lk_bad;

  tlb_cam_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .IDX_W(IDX_W),
                  .FILL_KEY(1'b0)) u_look (
    .valid(valid_q), .vpn(vpn_q), .glob(glob_q), .asid(asid_q),
    .key_vpn(lk_va[VA_W-1:PAGE_W]), .key_asid(lk_asid), .key_glob(1'b0),
    .hit(lk_hit), .idx(lk_idx));

  tlb_cam_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .IDX_W(IDX_W),
                  .FILL_KEY(1'b1)) u_fmatch (
    .valid(valid_q), .vpn(vpn_q), .glob(glob_q), .asid(asid_q),
    .key_vpn(fill_vpn), .key_asid(fill_asid), .key_glob(fill_global),
    .hit(fm_hit), .idx(fm_idx));

  tlb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst(rst), .fill_en(fill_en), .valid(valid_q),
    .reuse_hit(fm_hit), .reuse_idx(fm_idx), .slot(slot));

  assign lk_top = lk_va[VA_W-1:IA_W-1];
  assign lk_bad = !((&lk_top) || !(|lk_top));

  // valid bits: invalidation first, then the fill
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (inv_all) valid_q[i] <= 1'b0;
        else if (inv_asid_en && !glob_q[i] && asid_q[i] == inv_asid)
          valid_q[i] <= 1'b0;
      end
      if (fill_en) valid_q[slot] <= 1'b1;
    end
  end

  // payload storage, write-only by index, no reset
  always_ff @(posedge clk) begin
    if (fill_en) begin
      vpn_q[slot]  <= fill_vpn;
      ppn_q[slot]  <= fill_ppn;
      glob_q[slot] <= fill_global;
      asid_q[slot] <= fill_asid;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_upper <= 1'b0;
      rsp_ppn   <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && !lk_bad && lk_hit;
      rsp_miss  <= lk_valid && !lk_bad && !lk_hit;
      rsp_fault <= lk_valid && lk_bad;
      rsp_upper <= lk_va[VA_W-1];
      rsp_ppn   <= (lk_valid && !lk_bad && lk_hit) ? ppn_q[lk_idx] : '0;
    end
  end

  p_one_outcome_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1));
  p_rsp_on_r11: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);
  p_rsp_off_r11: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid);
  p_flush_r10: assert property (@(posedge clk) disable iff (rst)
    (inv_all && !fill_en) |=> (valid_q == '0));
  p_fill_lands_r10: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> (valid_q != '0));
  for (genvar i = 0; i < ENTRIES; i++) begin : g_inv_chk
    p_asid_gone_r9: assert property (@(posedge clk) disable iff (rst)
      (inv_asid_en && !fill_en && !inv_all) |=>
        !(valid_q[i] && !glob_q[i] && asid_q[i] == $past(inv_asid)));
  end
endmodule

// File: tb/asid_tlb_tb.sv
module asid_tlb_tb_top;
  localparam int N = 4;
  localparam int AW = 4;
  localparam int VA_W = 48;
  localparam int PW = 12;
  localparam int VW = VA_W - PW;
  localparam int PPW = 28;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lk_valid = 1'b0;
  logic [VA_W-1:0] lk_va = '0;
  logic [AW-1:0] lk_asid = '0;
  logic fill_en = 1'b0;
  logic [VW-1:0] fill_vpn = '0;
  logic [PPW-1:0] fill_ppn = '0;
  logic fill_global = 1'b0;
  logic [AW-1:0] fill_asid = '0;
  logic inv_asid_en = 1'b0;
  logic [AW-1:0] inv_asid = '0;
  logic inv_all = 1'b0;
  logic rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_upper;
  logic [PPW-1:0] rsp_ppn;

  always #5 clk = ~clk;

  asid_tlb #(.ENTRIES(N), .VA_W(VA_W), .PAGE_W(PW), .IA_W(39), .ASID_W(AW),
             .PPN_W(PPW)) dut_i (.*);

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model
  logic          m_v    [N];
  logic [VW-1:0] m_vpn  [N];
  logic [PPW-1:0] m_ppn [N];
  logic          m_g    [N];
  logic [AW-1:0] m_asid [N];
  int            m_rr;
  int            last_slot;
  logic          fill_pend;
  logic e_hit, e_miss, e_fault, e_up;
  logic [PPW-1:0] e_ppn;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [VA_W-1:0] va_of(input logic [VW-1:0] v);
    return {v, {PW{1'b0}}};
  endfunction

  task automatic calc(input logic [VA_W-1:0] va, input logic [AW-1:0] a);
    logic [9:0] top;
    int w;
    top = va[47:38];
    e_fault = !(top == 10'h0 || top == 10'h3FF);
    e_up = va[47];
    w = -1;
    for (int i = N - 1; i >= 0; i--)
      if (m_v[i] && m_vpn[i] == va[47:12] && (m_g[i] || m_asid[i] == a)) w = i;
    e_hit = !e_fault && (w >= 0);
    e_miss = !e_fault && (w < 0);
    e_ppn = e_hit ? m_ppn[w] : '0;
  endtask

  task automatic put_lookup(input logic [VA_W-1:0] va, input logic [AW-1:0] a);
    calc(va, a);
    lk_valid = 1'b1; lk_va = va; lk_asid = a;
  endtask

  task automatic put_fill(input logic [VW-1:0] v, input logic [PPW-1:0] p,
                          input logic g, input logic [AW-1:0] a);
    int s;
    s = -1;
    for (int i = N - 1; i >= 0; i--)
      if (m_v[i] && m_vpn[i] == v && m_g[i] == g && (g || m_asid[i] == a)) s = i;
    if (s < 0) for (int i = N - 1; i >= 0; i--) if (!m_v[i]) s = i;
    if (s < 0) begin s = m_rr; m_rr = (m_rr + 1) % N; end
    m_v[s] = 1'b1; m_vpn[s] = v; m_ppn[s] = p; m_g[s] = g; m_asid[s] = a;
    last_slot = s; fill_pend = 1'b1;
    fill_en = 1'b1; fill_vpn = v; fill_ppn = p; fill_global = g; fill_asid = a;
  endtask

  task automatic put_inv_all();
    for (int i = 0; i < N; i++) if (!(fill_pend && i == last_slot)) m_v[i] = 1'b0;
    inv_all = 1'b1;
  endtask

  task automatic put_inv_asid(input logic [AW-1:0] a);
    for (int i = 0; i < N; i++)
      if (!(fill_pend && i == last_slot) && !m_g[i] && m_asid[i] == a) m_v[i] = 1'b0;
    inv_asid_en = 1'b1; inv_asid = a;
  endtask

  task automatic step();
    @(negedge clk);
    lk_valid = 1'b0; fill_en = 1'b0; inv_all = 1'b0; inv_asid_en = 1'b0;
    fill_pend = 1'b0;
  endtask

  task automatic chk_rsp(input string tag);
    chk({tag, " valid"}, 64'(rsp_valid), 64'(1));
    chk({tag, " hit"},   64'(rsp_hit),   64'(e_hit));
    chk({tag, " miss"},  64'(rsp_miss),  64'(e_miss));
    chk({tag, " fault"}, 64'(rsp_fault), 64'(e_fault));
    chk({tag, " upper"}, 64'(rsp_upper), 64'(e_up));
    chk({tag, " ppn"},   64'(rsp_ppn),   64'(e_ppn));
  endtask

  task automatic lookup(input logic [VA_W-1:0] va, input logic [AW-1:0] a, input string tag);
    put_lookup(va, a);
    step();
    chk_rsp(tag);
  endtask

  task automatic fill(input logic [VW-1:0] v, input logic [PPW-1:0] p,
                      input logic g, input logic [AW-1:0] a);
    put_fill(v, p, g, a);
    step();
  endtask

  task automatic sweep(input logic [VW-1:0] v, input string tag);
    for (int a = 0; a < (1 << AW); a++) lookup(va_of(v), AW'(a), tag);
  endtask

  localparam logic [VW-1:0] UPV = {10'h3FF, 26'h0000123};

  initial begin
    for (int i = 0; i < N; i++) begin
      m_v[i] = 1'b0; m_vpn[i] = '0; m_ppn[i] = '0; m_g[i] = 1'b0; m_asid[i] = '0;
    end
    m_rr = 0; last_slot = 0; fill_pend = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rsp_valid after reset", 64'(rsp_valid), 64'(0));
    sweep(36'h10, "R1 empty miss");
    lookup(va_of(UPV), 4'h2, "R5 upper miss");

    // R4 / R2: same page, several owners
    fill(36'h10, 28'hA01, 1'b0, 4'h1);
    fill(36'h10, 28'hA02, 1'b0, 4'h2);
    fill(36'h10, 28'hA03, 1'b0, 4'h3);
    fill(36'h20, 28'hB01, 1'b0, 4'h1);
    sweep(36'h10, "R4 coexist");
    sweep(36'h20, "R2 asid match");
    lookup(va_of(36'h30), 4'h1, "R5 miss lower");

    // R7 replacement: table full, pointer walks 0,1,2,3,0
    for (int k = 0; k < 5; k++) begin
      fill(36'h40 + 36'(k), 28'hC00 + 28'(k), 1'b0, 4'h5);
      for (int j = 0; j <= k; j++) lookup(va_of(36'h40 + 36'(j)), 4'h5, "R7 round robin");
      sweep(36'h10, "R7 displaced");
    end

    // R8 overwrite in place
    fill(36'h44, 28'hD44, 1'b0, 4'h5);
    lookup(va_of(36'h44), 4'h5, "R8 overwrite ppn");
    for (int j = 1; j < 4; j++) lookup(va_of(36'h40 + 36'(j)), 4'h5, "R8 no displacement");

    // R3 / R12 priority between global and non-global for one page
    put_inv_all(); step();
    fill(36'h50, 28'hE05, 1'b0, 4'h5);
    fill(36'h50, 28'hE0F, 1'b1, 4'h0);
    sweep(36'h50, "R12 ng first");
    put_inv_all(); step();
    fill(36'h50, 28'hE0F, 1'b1, 4'h9);
    fill(36'h50, 28'hE05, 1'b0, 4'h5);
    sweep(36'h50, "R3 global");
    fill(UPV, 28'hF11, 1'b1, 4'h0);
    lookup(va_of(UPV), 4'h7, "R5 upper hit");

    // R6 faults, page present in table
    lookup({10'h1FF, 26'h0, 12'h0}, 4'h5, "R6 fault mixed");
    lookup({10'h200, 26'h50, 12'h0}, 4'h5, "R6 fault top");
    fill({10'h001, 26'h77}, 28'h777, 1'b1, 4'h0);
    lookup(va_of({10'h001, 26'h77}), 4'h1, "R6 fault present");

    // R9 invalidate by identifier
    put_inv_all(); step();
    fill(36'h60, 28'h161, 1'b0, 4'h1);
    fill(36'h60, 28'h162, 1'b0, 4'h2);
    fill(36'h61, 28'h1F0, 1'b1, 4'h1);
    fill(36'h62, 28'h163, 1'b0, 4'h1);
    put_inv_asid(4'h1); step();
    sweep(36'h60, "R9 by asid");
    sweep(36'h61, "R9 global kept");
    sweep(36'h62, "R9 cleared");

    // R11 same-cycle: lookup sees old contents
    put_lookup(va_of(36'h60), 4'h2);
    put_fill(36'h60, 28'h262, 1'b0, 4'h2);
    step(); chk_rsp("R11 lookup+fill old");
    lookup(va_of(36'h60), 4'h2, "R11 after fill");
    put_lookup(va_of(36'h61), 4'h3);
    put_inv_all();
    step(); chk_rsp("R11 lookup+inv_all old");
    lookup(va_of(36'h61), 4'h3, "R10 cleared");

    // R10 fill survives inv_all in same cycle
    fill(36'h70, 28'h370, 1'b0, 4'h4);
    fill(36'h71, 28'h371, 1'b0, 4'h4);
    put_fill(36'h72, 28'h372, 1'b1, 4'h0);
    put_inv_all(); step();
    lookup(va_of(36'h72), 4'h8, "R10 fill kept");
    lookup(va_of(36'h70), 4'h4, "R10 others gone");
    put_lookup(va_of(36'h72), 4'h0);
    put_inv_asid(4'h0);
    step(); chk_rsp("R11 lookup+inv_asid");

    step();
    chk("R11 idle rsp_valid", 64'(rsp_valid), 64'(0));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule